// File: doc/BRIEF.md
# DMA Channel Error Status Capture

This block collects error events raised by the channels of a multi-channel DMA engine and turns them into status that software can read. Each event arrives as a one-cycle pulse carrying a channel number and a type vector. The block keeps one sticky error flag per channel, which software reads as a low word (channels 0 to 31) and a high word (channels 32 to 63). It also keeps one summary word that describes the first error still outstanding. Detecting the errors is not part of this block.

Software uses three byte-wide write strobes that share one data byte. Each strobe names a channel in bits 5:0 of that byte. One strobe clears the channel's error flag. The other two set or clear the channel's error-interrupt enable. The interrupt request is raised while any channel has both its flag and its enable set. All state is held in registers and changes on the clock edge that samples a strobe or an event. Every output reflects that change one cycle after the inputs are driven.

Top module: `dma_err_capture`

## Requirements
- R1: After reset all flags, all enables, the summary word and the interrupt request are zero.
- R2: An event on channel c sets flag c. Channels 0 to 31 appear at bit c of the low flag word. Channels 32 to 63 appear at bit c-32 of the high flag word.
- R3: A captured summary word has this layout. Bit 31 is the valid flag. Bits 13:8 hold the erring channel. Bits 15, 14 and 7:0 hold the type vector's bits 15, 14 and 7:0, which mean group priority, channel priority, source address, source offset, destination address, destination offset, byte count/iteration, scatter/gather, source bus and destination bus. Bits 30:16 read zero.
- R4: An event updates the channel and type fields only if no flag would remain set after that cycle's clear. Otherwise the fields keep the first error.
- R5: Summary bit 31 is 1 exactly while at least one flag is set. When it falls, the channel and type fields keep their last captured value.
- R6: A clear-error write clears the flag of the channel in bits 5:0 of the write byte. Bits 7:6 of the byte are ignored.
- R7: A set-enable write sets the enable of the channel in bits 5:0, and a clear-enable write clears it. The enables are readable as a high word and a low word split the same way as the flags.
- R8: The interrupt request is the OR over all channels of flag AND enable. It follows the registered state with no added delay.
- R9: Bits 13:8 of the type vector input are ignored.
- R10: If an event and a clear-error write name the same channel in the same cycle, the flag ends up set.
- R11: If an event arrives in the cycle that clears the only remaining flag, that event is captured in the summary.
- R12: If set-enable and clear-enable name the same channel in the same cycle, the enable ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_valid_i | input | 1 | Error event strobe |
| err_ch_i | input | 6 | Channel of the error event |
| err_type_i | input | 16 | Error type vector (bits 15, 14, 7:0 used) |
| sw_wdata_i | input | 8 | Write byte shared by the three strobes; channel in bits 5:0 |
| clr_err_we_i | input | 1 | Clear the named channel's error flag |
| set_en_we_i | input | 1 | Set the named channel's interrupt enable |
| clr_en_we_i | input | 1 | Clear the named channel's interrupt enable |
| summary_o | output | 32 | First-error summary word |
| err_hi_o | output | 32 | Error flags, channels 63 to 32 |
| err_lo_o | output | 32 | Error flags, channels 31 to 0 |
| en_hi_o | output | 32 | Interrupt enables, channels 63 to 32 |
| en_lo_o | output | 32 | Interrupt enables, channels 31 to 0 |
| irq_o | output | 1 | Error interrupt request |

## Verification
The two functions that can fall in the same cycle are capturing an incoming error and a software clear-error write. The bench drives both strobes in one cycle in two ways. In the first, both name the same channel, and the flag is expected to stay set while the summary keeps the older error. In the second, the clear removes the last outstanding flag while the event names a different channel, and the summary is expected to take on the new channel and type. A third case drives set-enable and clear-enable together on one channel and expects the enable to end clear.

// File: rtl/errcap_pkg.sv
`timescale 1ns/1ps
package errcap_pkg;
  localparam int unsigned SUM_W      = 32;
  localparam int unsigned CHF_W      = 6;
  localparam int unsigned TYPE_W     = 16;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned MAX_CH     = 64;
  // type bits kept in the summary word; 13:8 are taken by the channel field
  localparam logic [TYPE_W-1:0] TYPE_KEEP = 16'hC0FF;
endpackage

// File: rtl/errcap_chan_dec.sv
`timescale 1ns/1ps
module errcap_chan_dec #(
  parameter int unsigned N = 64
) (
  input  logic                           en_i,
  input  logic [errcap_pkg::CHF_W-1:0]   ch_i,
  output logic [N-1:0]                   hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit_o[i] = en_i && (ch_i == errcap_pkg::CHF_W'(i));
  end
endmodule

// File: rtl/errcap_bitbank.sv
`timescale 1ns/1ps
module errcap_bitbank #(
  parameter int unsigned N        = 64,
  parameter bit          SET_WINS = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] d;

  if (SET_WINS) begin : g_set_wins
    assign d = (q_o & ~clr_i) | set_i;
  end else begin : g_clr_wins
    assign d = (q_o | set_i) & ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end
endmodule

// File: rtl/errcap_summary.sv
`timescale 1ns/1ps
module errcap_summary
  import errcap_pkg::*;
#(
  parameter int unsigned N = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      ev_hit_i,
  input  logic [CHF_W-1:0]  ev_ch_i,
  input  logic [TYPE_W-1:0] ev_type_i,
  input  logic [N-1:0]      flags_q_i,
  input  logic [N-1:0]      clr_i,
  output logic [SUM_W-1:0]  sum_o
);
  logic              capture;
  logic [CHF_W-1:0]  ch_q;
  logic [TYPE_W-1:0] type_q;

  // capture only if nothing stays flagged once this cycle's clear lands
  assign capture = (|ev_hit_i) && ((flags_q_i & ~clr_i) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q   <= '0;
      type_q <= '0;
    end else if (capture) begin
      ch_q   <= ev_ch_i;
      type_q <= ev_type_i & TYPE_KEEP;
    end
  end

  assign sum_o = {|flags_q_i, 15'b0, type_q[15:14], ch_q, type_q[7:0]};
endmodule

// File: rtl/dma_err_capture.sv
`timescale 1ns/1ps
module dma_err_capture
  import errcap_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_valid_i,
  input  logic [5:0]        err_ch_i,
  input  logic [15:0]       err_type_i,
  input  logic [7:0]        sw_wdata_i,
  input  logic              clr_err_we_i,
  input  logic              set_en_we_i,
  input  logic              clr_en_we_i,
  output logic [31:0]       summary_o,
  output logic [31:0]       err_hi_o,
  output logic [31:0]       err_lo_o,
  output logic [31:0]       en_hi_o,
  output logic [31:0]       en_lo_o,
  output logic              irq_o
);
  logic [CHF_W-1:0]  wr_ch;
  logic [1:0]        unused_wr_hi;
  logic [NUM_CH-1:0] ev_hit, clr_err_hit, set_en_hit, clr_en_hit;
  logic [NUM_CH-1:0] flags_q, en_q;
  logic [MAX_CH-1:0] flags_w, en_w;

  assign wr_ch        = sw_wdata_i[CHF_W-1:0];
  assign unused_wr_hi = sw_wdata_i[7:6];

  errcap_chan_dec #(.N(NUM_CH)) u_dec_ev (
    .en_i(err_valid_i), .ch_i(err_ch_i), .hit_o(ev_hit));
  errcap_chan_dec #(.N(NUM_CH)) u_dec_clr_err (
    .en_i(clr_err_we_i), .ch_i(wr_ch), .hit_o(clr_err_hit));
  errcap_chan_dec #(.N(NUM_CH)) u_dec_set_en (
    .en_i(set_en_we_i), .ch_i(wr_ch), .hit_o(set_en_hit));
  errcap_chan_dec #(.N(NUM_CH)) u_dec_clr_en (
    .en_i(clr_en_we_i), .ch_i(wr_ch), .hit_o(clr_en_hit));

  // a new error outranks a clear; a disable outranks an enable
  errcap_bitbank #(.N(NUM_CH), .SET_WINS(1'b1)) u_flags (
    .clk_i, .rst_ni, .set_i(ev_hit), .clr_i(clr_err_hit), .q_o(flags_q));
  errcap_bitbank #(.N(NUM_CH), .SET_WINS(1'b0)) u_enables (
    .clk_i, .rst_ni, .set_i(set_en_hit), .clr_i(clr_en_hit), .q_o(en_q));

  errcap_summary #(.N(NUM_CH)) u_summary (
    .clk_i, .rst_ni,
    .ev_hit_i(ev_hit), .ev_ch_i(err_ch_i), .ev_type_i(err_type_i),
    .flags_q_i(flags_q), .clr_i(clr_err_hit), .sum_o(summary_o));

  always_comb begin
    flags_w = '0;
    en_w    = '0;
    flags_w[NUM_CH-1:0] = flags_q;
    en_w[NUM_CH-1:0]    = en_q;
  end

  assign err_hi_o = flags_w[2*WORD_W-1:WORD_W];
  assign err_lo_o = flags_w[WORD_W-1:0];
  assign en_hi_o  = en_w[2*WORD_W-1:WORD_W];
  assign en_lo_o  = en_w[WORD_W-1:0];
  assign irq_o    = |(flags_q & en_q);
endmodule

// File: rtl/dma_err_capture_chk.sv
`timescale 1ns/1ps
module dma_err_capture_chk #(
  parameter int unsigned NUM_CH = 64
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        err_valid_i,
  input logic [5:0]  err_ch_i,
  input logic [15:0] err_type_i,
  input logic [7:0]  sw_wdata_i,
  input logic        clr_err_we_i,
  input logic        set_en_we_i,
  input logic        clr_en_we_i,
  input logic [31:0] summary_o,
  input logic [31:0] err_hi_o,
  input logic [31:0] err_lo_o,
  input logic [31:0] en_hi_o,
  input logic [31:0] en_lo_o,
  input logic        irq_o
);
  logic [63:0] all_flags, all_en;
  logic        ch_ok, same_ch, unused_chk;
  assign all_flags  = {err_hi_o, err_lo_o};
  assign all_en     = {en_hi_o, en_lo_o};
  assign ch_ok      = int'(err_ch_i) < int'(NUM_CH);
  assign same_ch    = err_valid_i && (err_ch_i == sw_wdata_i[5:0]);
  assign unused_chk = ^{err_type_i, set_en_we_i};

  assert_flag_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_i && ch_ok) |=> all_flags[$past(err_ch_i)]);

  assert_first_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_flags != 64'd0 && !clr_err_we_i) |=> $stable(summary_o[30:0]));

  assert_valid_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err_we_i && !err_valid_i && $countones(all_flags) == 1
     && all_flags[sw_wdata_i[5:0]]) |=> !summary_o[31]);

  assert_clear_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err_we_i && !same_ch) |=> !all_flags[$past(sw_wdata_i[5:0])]);

  assert_irq_needs_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> all_flags != 64'd0);

  assert_irq_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_en == 64'd0 |-> !irq_o);

  assert_set_beats_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err_we_i && same_ch && ch_ok) |=> all_flags[$past(err_ch_i)]);

  assert_disable_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_we_i |=> !all_en[$past(sw_wdata_i[5:0])]);
endmodule

bind dma_err_capture dma_err_capture_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .err_valid_i(err_valid_i), .err_ch_i(err_ch_i),
  .err_type_i(err_type_i), .sw_wdata_i(sw_wdata_i), .clr_err_we_i(clr_err_we_i),
  .set_en_we_i(set_en_we_i), .clr_en_we_i(clr_en_we_i), .summary_o(summary_o),
  .err_hi_o(err_hi_o), .err_lo_o(err_lo_o), .en_hi_o(en_hi_o), .en_lo_o(en_lo_o),
  .irq_o(irq_o));

// File: tb/tb_dma_err_capture.sv
`timescale 1ns/1ps
module tb_dma_err_capture;
  typedef struct packed {
    logic [31:0] sum;
    logic [63:0] fl;
    logic [63:0] en;
    logic        irq;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0;
  logic [5:0]  err_ch = '0;
  logic [15:0] err_type = '0;
  logic [7:0]  wdata = '0;
  logic        clr_err = 1'b0, set_en = 1'b0, clr_en = 1'b0;
  logic [31:0] summary, err_hi, err_lo, en_hi, en_lo;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  exp_t  exp_q[$];
  string req_q[$];

  logic [63:0] m_fl = '0, m_en = '0;
  logic [5:0]  m_ch = '0;
  logic [15:0] m_ty = '0;

  always #2.5 clk = ~clk;

  dma_err_capture dut (
    .clk_i(clk), .rst_ni(rst_n), .err_valid_i(err_valid), .err_ch_i(err_ch),
    .err_type_i(err_type), .sw_wdata_i(wdata), .clr_err_we_i(clr_err),
    .set_en_we_i(set_en), .clr_en_we_i(clr_en), .summary_o(summary),
    .err_hi_o(err_hi), .err_lo_o(err_lo), .en_hi_o(en_hi), .en_lo_o(en_lo),
    .irq_o(irq));

  task automatic compare(input exp_t e, input string req);
    n_cmp++;
    if (summary !== e.sum || {err_hi, err_lo} !== e.fl ||
        {en_hi, en_lo} !== e.en || irq !== e.irq) begin
      n_bad++;
      $display("FAIL %s: sum=%h exp %h flags=%h exp %h en=%h exp %h irq=%b exp %b",
               req, summary, e.sum, {err_hi, err_lo}, e.fl, {en_hi, en_lo}, e.en,
               irq, e.irq);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected outcome
  task automatic step(input bit ev, input logic [5:0] ch, input logic [15:0] ty,
                      input logic [7:0] wd, input bit ce, input bit se,
                      input bit cn, input string req);
    logic [63:0] cm, sm, sem, cem, keep;
    exp_t e;
    @(negedge clk);
    err_valid = ev; err_ch = ch; err_type = ty;
    wdata = wd; clr_err = ce; set_en = se; clr_en = cn;
    cm  = ce ? (64'd1 << wd[5:0]) : 64'd0;
    sm  = ev ? (64'd1 << ch) : 64'd0;
    sem = se ? (64'd1 << wd[5:0]) : 64'd0;
    cem = cn ? (64'd1 << wd[5:0]) : 64'd0;
    keep = m_fl & ~cm;
    if (ev && keep == 64'd0) begin
      m_ch = ch;
      m_ty = ty & 16'hC0FF;
    end
    m_fl = keep | sm;
    m_en = (m_en | sem) & ~cem;
    e.fl  = m_fl;
    e.en  = m_en;
    e.irq = |(m_fl & m_en);
    e.sum = {(m_fl != 64'd0), 15'd0, m_ty[15:14], m_ch, m_ty[7:0]};
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  // monitor: compares just after the edge that consumed the stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), req_q.pop_front());
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, exp done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    exp_t z;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    z = '0;
    compare(z, "R1");
    // first error: channel 3, source address
    step(1, 6'd3, 16'h0080, 8'd0, 0, 0, 0, "R2 R3");
    // second error in high word does not replace the summary
    step(1, 6'd40, 16'h4000, 8'd0, 0, 0, 0, "R4");
    step(0, 6'd0, 16'h0, 8'd40, 0, 1, 0, "R7 R8");
    // clear with junk in bits 7:6
    step(0, 6'd0, 16'h0, 8'hC3, 1, 0, 0, "R6 R5");
    step(0, 6'd0, 16'h0, 8'd40, 0, 0, 1, "R8");
    step(0, 6'd0, 16'h0, 8'd40, 1, 0, 0, "R5");
    // type bits 13:8 must not leak into the channel field
    step(1, 6'd0, 16'h3F01, 8'd0, 0, 0, 0, "R9 R3");
    // event and clear on one channel in the same cycle
    step(1, 6'd10, 16'h0002, 8'd10, 1, 0, 0, "R10");
    step(0, 6'd0, 16'h0, 8'd10, 1, 0, 0, "R6");
    // event while the last flag is being cleared
    step(1, 6'd20, 16'h0020, 8'd0, 1, 0, 0, "R11");
    step(0, 6'd0, 16'h0, 8'd20, 0, 1, 1, "R12");
    step(0, 6'd0, 16'h0, 8'd20, 0, 1, 0, "R8 R7");
    step(1, 6'd63, 16'h8000, 8'd0, 0, 0, 0, "R2 R4");
    step(1, 6'd31, 16'h0001, 8'd20, 1, 0, 0, "R2 R4");
    step(0, 6'd0, 16'h0, 8'd0, 0, 0, 0, "R8");
    step(0, 6'd0, 16'h0, 8'd63, 1, 0, 0, "R6");
    step(0, 6'd0, 16'h0, 8'd31, 1, 0, 0, "R5");
    step(0, 6'd0, 16'h0, 8'd0, 0, 0, 0, "R5");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule